// File: doc/BRIEF.md
# Multi-State Trigger Sequencer

This block is the decision core of a logic analyzer trigger. Every sample clock it receives a vector of match flags from external trigger terms such as masked comparators, range checks and edge detectors. It adds the expiry flags of two built-in 36-bit timers to that vector. It then walks a programmable state machine of 16 states.

Each state has three conditions: hit, else and capture. Each condition selects a subset of the terms and reduces it with one logic operator. A state also has a hit-count target and a set of actions that are taken on a full hit.

The outputs are:
- `runOut`, the trigger, which is sticky until the next arm.
- `capEn`, which gates which samples the memory stores before the trigger and is forced high after it.
- The current state index.
- The timer expiry flags.

Software fills the per-state configuration and the timer limits through a write-only address/data port. It then pulses `arm`.

Top module: `trigSeqTop`

## Requirements
- R1: After reset, and before the first `arm`, `curState` is 0, `runOut` is 0, `capEn` is 0 and `timerExp` is 0. Match inputs have no effect on these outputs.
- R2: An `arm` pulse does the following on that clock edge: sets the state to 0, clears the hit counter and the trigger, stops both timers and clears their expiry flags, and starts sequencing.
- R3: The term vector has `matchIn` in bits 0..7, timer 0 expiry in bit 8 and timer 1 expiry in bit 9. A condition has a mask and a 3-bit operator. The operator codes are 0 AND, 1 NAND, 2 OR, 3 NOR, 4 XOR, 5 XNOR, and 6 or 7 for never true. The operator is applied to the masked terms only. An AND over an empty mask is true.
- R4: A full hit occurs on the cycle in which the hit condition has been true for the N-th time since the state was entered, where N is the 20-bit target and 0 acts as 1. Cycles without a hit do not clear the count. Any state change clears it.
- R5: The action bits of a full hit are bit0 advance to state+1, bit1 assert the trigger, bit2/bit3 start/stop timer 0, and bit4/bit5 start/stop timer 1. Advance saturates at state 15.
- R6: When the else condition is true and there is no full hit, the next state is the configured else target. A full hit takes priority over else.
- R7: When there is neither a full hit nor a true else condition, the state is unchanged.
- R8: `capEn` is 0 while not armed. It equals the current state's capture condition while armed and not triggered, and it is 1 once triggered.
- R9: A started timer sets its expiry flag on the L-th clock edge after the starting edge, where L is its 36-bit limit. A limit of 0 never expires. A stop before then prevents expiry. The flag stays set until restart or arm.
- R10: Once `runOut` is 1, it and `curState` hold until the next `arm`.
- R11: Writes use the address bits `[7]=0`, `[6:3]` state and `[2:0]` field. The fields are:
  - Field 0 is hit and field 2 is capture, each with the mask in data `[9:0]` and the operator in `[26:24]`.
  - Field 1 is else, with the same layout plus the target in `[31:28]`.
  - Field 3 is the count target in `[19:0]`.
  - Field 4 holds the actions in `[5:0]`.
  
  Address `0x80+2*i` writes bits `[31:0]` of timer i's limit, and `0x81+2*i` writes bits `[35:32]` from data `[3:0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Restart pulse for sequencing |
| matchIn | input | 8 | External trigger term flags |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 8 | Configuration address |
| cfgData | input | 32 | Configuration write data |
| curState | output | 4 | Current sequencer state |
| runOut | output | 1 | Trigger fired (sticky) |
| capEn | output | 1 | Sample-store enable |
| timerExp | output | 2 | Timer expiry flags |

## Verification
The bench drives the sequencer along three armed paths.

The first path climbs from state 0 through a three-match count interrupted by an idle cycle. It then takes an XOR hit that starts timer 0 and waits for that timer's expiry term to fire the trigger. This separates count retention from count reset and tests the timer latency exactly.

The second path leaves a partly counted state through an else jump and later returns. An early full hit there would expose a counter that was not cleared. The path also covers NOR, XNOR, saturation at the last state and a zero timer limit.

The third path presents hit and else together to show priority, then stops a running timer and watches that expiry never arrives.

// File: rtl/trigSeqPkg.sv
package trigSeqPkg;

  localparam int TMR_N = 2;

  // field selectors inside a state's address window
  localparam logic [2:0] FLD_HIT  = 3'd0;
  localparam logic [2:0] FLD_ELSE = 3'd1;
  localparam logic [2:0] FLD_CAP  = 3'd2;
  localparam logic [2:0] FLD_CNT  = 3'd3;
  localparam logic [2:0] FLD_ACT  = 3'd4;

  localparam int ACT_W = 2 + 2 * TMR_N;

  typedef enum logic [2:0] {
    OP_AND  = 3'd0,
    OP_NAND = 3'd1,
    OP_OR   = 3'd2,
    OP_NOR  = 3'd3,
    OP_XOR  = 3'd4,
    OP_XNOR = 3'd5,
    OP_OFF6 = 3'd6,
    OP_OFF7 = 3'd7
  } combOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             clrCnt;
    logic             incCnt;
    logic             killTmr;
    logic [TMR_N-1:0] tmrStart;
    logic [TMR_N-1:0] tmrStop;
  } seqStrobe_t;

  // evaluated conditions of the current state, datapath to control
  typedef struct packed {
    logic             hitCond;
    logic             elseCond;
    logic             capCond;
    logic             cntReached;
    logic             advance;
    logic             fire;
    logic [TMR_N-1:0] start;
    logic [TMR_N-1:0] stop;
  } condFlags_t;

endpackage

// File: rtl/condEval.sv
module condEval
  import trigSeqPkg::*;
#(
  parameter int TERMS = 10
) (
  input  logic [TERMS-1:0] terms,
  input  logic [TERMS-1:0] mask,
  input  logic [2:0]       op,
  output logic             match
);
  logic [TERMS-1:0] picked;

  always_comb begin
    picked = terms & mask;
    unique case (combOp_e'(op))
      OP_AND:  match = &(terms | ~mask);
      OP_NAND: match = ~&(terms | ~mask);
      OP_OR:   match = |picked;
      OP_NOR:  match = ~|picked;
      OP_XOR:  match = ^picked;
      OP_XNOR: match = ~^picked;
      default: match = 1'b0;
    endcase
  end
endmodule

// File: rtl/seqTimer.sv
module seqTimer #(
  parameter int W = 36
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         kill,
  input  logic         start,
  input  logic         stop,
  input  logic [W-1:0] limit,
  output logic         expired
);
  localparam int XW = W + 1;

  logic [W-1:0] count;
  logic         running;
  logic [XW-1:0] nextCount;

  assign nextCount = {1'b0, count} + XW'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count   <= '0;
      running <= 1'b0;
      expired <= 1'b0;
    end else if (kill) begin
      count   <= '0;
      running <= 1'b0;
      expired <= 1'b0;
    end else if (start) begin
      count   <= '0;
      running <= 1'b1;
      expired <= 1'b0;
    end else if (stop) begin
      running <= 1'b0;
    end else if (running) begin
      count <= nextCount[W-1:0];
      if (nextCount == {1'b0, limit}) begin
        expired <= 1'b1;
        running <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/trigSeqData.sv
module trigSeqData
  import trigSeqPkg::*;
#(
  parameter int NUM_STATES = 16,
  parameter int STATE_W    = 4,
  parameter int NUM_EXT    = 8,
  parameter int CNT_W      = 20,
  parameter int TMR_W      = 36,
  parameter int ADDR_W     = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EXT-1:0] matchIn,
  input  logic               cfgWe,
  input  logic [ADDR_W-1:0]  cfgAddr,
  input  logic [31:0]        cfgData,
  input  logic [STATE_W-1:0] curState,
  input  seqStrobe_t         strobe,
  output condFlags_t         flags,
  output logic [STATE_W-1:0] elseTarget,
  output logic [TMR_N-1:0]   tmrExp
);
  localparam int NUM_TERMS = NUM_EXT + TMR_N;
  localparam int HI_W      = TMR_W - 32;
  localparam int CXW       = CNT_W + 1;

  logic [NUM_TERMS-1:0] hitMask  [NUM_STATES];
  logic [NUM_TERMS-1:0] elseMask [NUM_STATES];
  logic [NUM_TERMS-1:0] capMask  [NUM_STATES];
  logic [2:0]           hitOp    [NUM_STATES];
  logic [2:0]           elseOp   [NUM_STATES];
  logic [2:0]           capOp    [NUM_STATES];
  logic [STATE_W-1:0]   elseTgt  [NUM_STATES];
  logic [CNT_W-1:0]     cntTgt   [NUM_STATES];
  logic [ACT_W-1:0]     actBits  [NUM_STATES];
  logic [TMR_W-1:0]     tmrLimit [TMR_N];

  logic                 tmrSpace;
  logic [STATE_W-1:0]   wrState;
  logic [2:0]           wrField;

  assign tmrSpace = cfgAddr[ADDR_W-1];
  assign wrState  = cfgAddr[3 +: STATE_W];
  assign wrField  = cfgAddr[2:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_STATES; s++) begin
        hitMask[s]  <= '0;
        elseMask[s] <= '0;
        capMask[s]  <= '0;
        hitOp[s]    <= '0;
        elseOp[s]   <= '0;
        capOp[s]    <= '0;
        elseTgt[s]  <= '0;
        cntTgt[s]   <= '0;
        actBits[s]  <= '0;
      end
      for (int t = 0; t < TMR_N; t++) tmrLimit[t] <= '0;
    end else if (cfgWe) begin
      if (tmrSpace) begin
        if (cfgAddr[0]) tmrLimit[cfgAddr[1]][TMR_W-1:32] <= cfgData[HI_W-1:0];
        else            tmrLimit[cfgAddr[1]][31:0]       <= cfgData;
      end else begin
        unique case (wrField)
          FLD_HIT: begin
            hitMask[wrState] <= cfgData[NUM_TERMS-1:0];
            hitOp[wrState]   <= cfgData[26:24];
          end
          FLD_ELSE: begin
            elseMask[wrState] <= cfgData[NUM_TERMS-1:0];
            elseOp[wrState]   <= cfgData[26:24];
            elseTgt[wrState]  <= cfgData[28 +: STATE_W];
          end
          FLD_CAP: begin
            capMask[wrState] <= cfgData[NUM_TERMS-1:0];
            capOp[wrState]   <= cfgData[26:24];
          end
          FLD_CNT: cntTgt[wrState]  <= cfgData[CNT_W-1:0];
          FLD_ACT: actBits[wrState] <= cfgData[ACT_W-1:0];
          default: ;
        endcase
      end
    end
  end

  logic [NUM_TERMS-1:0] terms;
  assign terms = {tmrExp, matchIn};

  condEval #(.TERMS(NUM_TERMS)) i_hitEval (
    .terms(terms), .mask(hitMask[curState]), .op(hitOp[curState]), .match(flags.hitCond));
  condEval #(.TERMS(NUM_TERMS)) i_elseEval (
    .terms(terms), .mask(elseMask[curState]), .op(elseOp[curState]), .match(flags.elseCond));
  condEval #(.TERMS(NUM_TERMS)) i_capEval (
    .terms(terms), .mask(capMask[curState]), .op(capOp[curState]), .match(flags.capCond));

  // occurrence counter of the current state
  logic [CNT_W-1:0] hitCnt;
  logic [CNT_W-1:0] effTgt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               hitCnt <= '0;
    else if (strobe.clrCnt)  hitCnt <= '0;
    else if (strobe.incCnt)  hitCnt <= hitCnt + CNT_W'(1);
  end

  assign effTgt           = (cntTgt[curState] == '0) ? CNT_W'(1) : cntTgt[curState];
  assign flags.cntReached = ({1'b0, hitCnt} + CXW'(1)) >= {1'b0, effTgt};
  assign flags.advance    = actBits[curState][0];
  assign flags.fire       = actBits[curState][1];
  assign elseTarget       = elseTgt[curState];

  for (genvar i = 0; i < TMR_N; i++) begin : g_tmr
    assign flags.start[i] = actBits[curState][2 + 2*i];
    assign flags.stop[i]  = actBits[curState][3 + 2*i];

    seqTimer #(.W(TMR_W)) i_timer (
      .clk    (clk),
      .rstN   (rstN),
      .kill   (strobe.killTmr),
      .start  (strobe.tmrStart[i]),
      .stop   (strobe.tmrStop[i]),
      .limit  (tmrLimit[i]),
      .expired(tmrExp[i])
    );
  end
endmodule

// File: rtl/trigSeqCtrl.sv
module trigSeqCtrl
  import trigSeqPkg::*;
#(
  parameter int NUM_STATES = 16,
  parameter int STATE_W    = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               arm,
  input  condFlags_t         flags,
  input  logic [STATE_W-1:0] elseTarget,
  output logic [STATE_W-1:0] curState,
  output logic               armedQ,
  output logic               trigQ,
  output seqStrobe_t         strobe
);
  localparam logic [STATE_W-1:0] LAST = STATE_W'(NUM_STATES - 1);

  logic active;
  logic fullHit;

  assign active  = armedQ & ~trigQ;
  assign fullHit = active & flags.hitCond & flags.cntReached;

  always_comb begin
    strobe = '0;
    if (arm) begin
      strobe.killTmr = 1'b1;
      strobe.clrCnt  = 1'b1;
    end else if (fullHit) begin
      strobe.clrCnt   = 1'b1;
      strobe.tmrStart = flags.start;
      strobe.tmrStop  = flags.stop;
    end else if (active && flags.elseCond) begin
      strobe.clrCnt = 1'b1;
    end else if (active && flags.hitCond) begin
      strobe.incCnt = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curState <= '0;
      armedQ   <= 1'b0;
      trigQ    <= 1'b0;
    end else if (arm) begin
      curState <= '0;
      armedQ   <= 1'b1;
      trigQ    <= 1'b0;
    end else if (fullHit) begin
      if (flags.fire) trigQ <= 1'b1;
      if (flags.advance && curState != LAST) curState <= curState + STATE_W'(1);
    end else if (active && flags.elseCond) begin
      curState <= elseTarget;
    end
  end
endmodule

// File: rtl/trigSeqTop.sv
module trigSeqTop
  import trigSeqPkg::*;
#(
  parameter int NUM_STATES = 16,
  parameter int NUM_EXT    = 8,
  parameter int CNT_W      = 20,
  parameter int TMR_W      = 36
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                arm,
  input  logic [NUM_EXT-1:0]                  matchIn,
  input  logic                                cfgWe,
  input  logic [$clog2(NUM_STATES)+3:0]       cfgAddr,
  input  logic [31:0]                         cfgData,
  output logic [$clog2(NUM_STATES)-1:0]       curState,
  output logic                                runOut,
  output logic                                capEn,
  output logic [1:0]                          timerExp
);
  localparam int STATE_W = $clog2(NUM_STATES);
  localparam int ADDR_W  = STATE_W + 4;

  condFlags_t         flags;
  seqStrobe_t         strobe;
  logic [STATE_W-1:0] elseTarget;
  logic               armedQ;
  logic               trigQ;
  logic               hitCondW;
  logic               elseCondW;

  trigSeqData #(
    .NUM_STATES(NUM_STATES), .STATE_W(STATE_W), .NUM_EXT(NUM_EXT),
    .CNT_W(CNT_W), .TMR_W(TMR_W), .ADDR_W(ADDR_W)
  ) i_data (
    .clk(clk), .rstN(rstN), .matchIn(matchIn), .cfgWe(cfgWe),
    .cfgAddr(cfgAddr), .cfgData(cfgData), .curState(curState),
    .strobe(strobe), .flags(flags), .elseTarget(elseTarget), .tmrExp(timerExp)
  );

  trigSeqCtrl #(.NUM_STATES(NUM_STATES), .STATE_W(STATE_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .arm(arm), .flags(flags), .elseTarget(elseTarget),
    .curState(curState), .armedQ(armedQ), .trigQ(trigQ), .strobe(strobe)
  );

  assign hitCondW  = flags.hitCond;
  assign elseCondW = flags.elseCond;
  assign runOut    = trigQ;
  assign capEn     = trigQ | (armedQ & flags.capCond);
endmodule

// File: rtl/trigSeqChk.sv
module trigSeqChk #(
  parameter int STATE_W = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               arm,
  input logic [STATE_W-1:0] curState,
  input logic               runOut,
  input logic               capEn,
  input logic               armedQ,
  input logic               hitCond,
  input logic               elseCond
);
  p_arm_home_r2: assert property (@(posedge clk) disable iff (!rstN)
    arm |=> (curState == '0 && !runOut));

  p_run_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (runOut && !arm) |=> (runOut && $stable(curState)));

  p_cap_after_run_r8: assert property (@(posedge clk) disable iff (!rstN)
    runOut |-> capEn);

  p_idle_cap_r1: assert property (@(posedge clk) disable iff (!rstN)
    !armedQ |-> (!capEn && !runOut));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (armedQ && !runOut && !arm && !hitCond && !elseCond) |=> $stable(curState));
endmodule

bind trigSeqTop trigSeqChk i_chk (
  .clk(clk), .rstN(rstN), .arm(arm), .curState(curState), .runOut(runOut),
  .capEn(capEn), .armedQ(armedQ), .hitCond(hitCondW), .elseCond(elseCondW)
);

// File: tb/test_trigSeqTop.sv
module test_trigSeqTop;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        arm = 1'b0;
  logic [7:0]  matchIn = '0;
  logic        cfgWe = 1'b0;
  logic [7:0]  cfgAddr = '0;
  logic [31:0] cfgData = '0;
  logic [3:0]  curState;
  logic        runOut;
  logic        capEn;
  logic [1:0]  timerExp;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  typedef struct {
    string      tag;
    logic [3:0] st;
    logic       run;
    logic       cap;
    logic [1:0] tex;
  } item_t;

  item_t sb[$];

  always #10 clk = ~clk;

  trigSeqTop i_trigSeqTop (
    .clk(clk), .rstN(rstN), .arm(arm), .matchIn(matchIn), .cfgWe(cfgWe),
    .cfgAddr(cfgAddr), .cfgData(cfgData), .curState(curState),
    .runOut(runOut), .capEn(capEn), .timerExp(timerExp)
  );

  // monitor: mid-cycle, compare outputs against queued expectations
  always @(negedge clk) begin
    item_t it;
    while (sb.size() != 0) begin
      it = sb.pop_front();
      total++;
      if (curState !== it.st || runOut !== it.run || capEn !== it.cap || timerExp !== it.tex) begin
        bad++;
        $display("FAIL %s: actual st=%0d run=%0b cap=%0b tex=%b expected st=%0d run=%0b cap=%0b tex=%b",
                 it.tag, curState, runOut, capEn, timerExp, it.st, it.run, it.cap, it.tex);
      end
    end
  end

  task automatic step(input logic [7:0] m, input logic a);
    @(posedge clk);
    #3;
    cfgWe   = 1'b0;
    matchIn = m;
    arm     = a;
  endtask

  task automatic want(input string tag, input int st, input bit run, input bit cap, input int tex);
    item_t it;
    it.tag = tag;
    it.st  = 4'(st);
    it.run = run;
    it.cap = cap;
    it.tex = 2'(tex);
    sb.push_back(it);
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    @(posedge clk);
    #3;
    cfgWe   = 1'b1;
    cfgAddr = 8'(addr);
    cfgData = data;
    matchIn = '0;
    arm     = 1'b0;
  endtask

  function automatic int sa(input int s, input int f);
    return s * 8 + f;
  endfunction

  function automatic logic [31:0] cd(input int op, input int mask, input int tgt);
    return (32'(tgt) << 28) | (32'(op) << 24) | 32'(mask);
  endfunction

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(20 * 20000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #3 rstN = 1'b1;

    // R1: idle after reset, matches ignored before arm
    step(8'h00, 0); want("R1 reset", 0, 0, 0, 0);
    step(8'hFF, 0); want("R1 unarmed", 0, 0, 0, 0);
    step(8'h03, 0); want("R1 unarmed", 0, 0, 0, 0);

    // R11 configuration
    wr(sa(0, 0), cd(0, 'h003, 0));
    wr(sa(0, 1), cd(2, 'h080, 5));
    wr(sa(0, 2), cd(2, 'h004, 0));
    wr(sa(0, 3), 32'd3);
    wr(sa(0, 4), 32'h01);
    wr(sa(1, 0), cd(4, 'h030, 0));
    wr(sa(1, 1), cd(7, 0, 0));
    wr(sa(1, 2), cd(6, 0, 0));
    wr(sa(1, 3), 32'd1);
    wr(sa(1, 4), 32'h05);
    wr(sa(2, 0), cd(0, 'h100, 0));
    wr(sa(2, 1), cd(7, 0, 0));
    wr(sa(2, 2), cd(1, 'h003, 0));
    wr(sa(2, 3), 32'd1);
    wr(sa(2, 4), 32'h02);
    wr(sa(5, 0), cd(3, 'h00F, 0));
    wr(sa(5, 1), cd(4, 'h003, 0));
    wr(sa(5, 2), cd(5, 'h003, 0));
    wr(sa(5, 3), 32'd2);
    wr(sa(5, 4), 32'h01);
    wr(sa(6, 0), cd(7, 0, 0));
    wr(sa(6, 1), cd(0, 'h040, 15));
    wr(sa(15, 4), 32'h11);
    wr('h80, 32'd4);
    wr('h81, 32'd0);

    // path 1
    step(8'h00, 1);
    step(8'h04, 0); want("R2 arm home / R8 OR capture", 0, 0, 1, 0);
    step(8'h03, 0); want("R4 count 1", 0, 0, 0, 0);
    step(8'h03, 0); want("R4 count 2", 0, 0, 0, 0);
    step(8'h00, 0); want("R7 idle hold", 0, 0, 0, 0);
    step(8'h03, 0); want("R4 count 3", 0, 0, 0, 0);
    step(8'h00, 0); want("R4 full hit advance", 1, 0, 0, 0);
    step(8'h30, 0); want("R3 XOR even", 1, 0, 0, 0);
    step(8'h10, 0); want("R3 XOR odd", 1, 0, 0, 0);
    step(8'h00, 0); want("R5 advance, R3 NAND cap", 2, 0, 1, 0);
    step(8'h03, 0); want("R3 NAND false", 2, 0, 0, 0);
    step(8'h00, 0); want("R9 timer running", 2, 0, 1, 0);
    step(8'h00, 0); want("R9 timer running", 2, 0, 1, 0);
    step(8'h00, 0); want("R9 timer expired", 2, 0, 1, 1);
    step(8'h00, 0); want("R5 fire", 2, 1, 1, 1);
    step(8'hFF, 0); want("R10 triggered hold", 2, 1, 1, 1);
    step(8'h00, 0); want("R10 triggered hold", 2, 1, 1, 1);

    // path 2
    step(8'h00, 1);
    step(8'h03, 0); want("R2 rearm clears", 0, 0, 0, 0);
    step(8'h03, 0); want("R4 partial", 0, 0, 0, 0);
    step(8'h80, 0); want("R6 pre else", 0, 0, 0, 0);
    step(8'h00, 0); want("R6 else jump, R3 XNOR cap", 5, 0, 1, 0);
    step(8'h01, 0); want("R3 XNOR false", 5, 0, 0, 0);
    step(8'h80, 0); want("R6 else to 0", 0, 0, 0, 0);
    step(8'h00, 0); want("R6 else to 5", 5, 0, 1, 0);
    step(8'h10, 0); want("R4 counter cleared on change", 5, 0, 1, 0);
    step(8'h40, 0); want("R3 NOR hit advance", 6, 0, 1, 0);
    step(8'h00, 0); want("R6 else to 15", 15, 0, 1, 0);
    step(8'h00, 0); want("R5 saturate", 15, 0, 1, 0);
    step(8'h00, 0); want("R9 zero limit", 15, 0, 1, 0);
    step(8'h00, 0); want("R9 zero limit", 15, 0, 1, 0);
    step(8'h00, 0); want("R9 zero limit", 15, 0, 1, 0);

    // path 3
    wr(sa(0, 3), 32'd1);
    wr(sa(0, 4), 32'h05);
    wr(sa(1, 4), 32'h09);
    step(8'h00, 1);
    step(8'h83, 0); want("R2 arm", 0, 0, 0, 0);
    step(8'h10, 0); want("R6 hit beats else", 1, 0, 0, 0);
    step(8'h00, 0); want("R9 stopped", 2, 0, 1, 0);
    step(8'h00, 0); want("R9 stopped", 2, 0, 1, 0);
    step(8'h00, 0); want("R9 stopped", 2, 0, 1, 0);
    step(8'h00, 0); want("R9 stopped", 2, 0, 1, 0);
    step(8'h00, 0); want("R9 stopped", 2, 0, 1, 0);

    @(posedge clk);
    @(posedge clk);
    finished = 1'b1;
    finish_run();
  end
endmodule